// File: doc/BRIEF.md
# Shared Queue Entry Budget Allocator

This block keeps the entry budget of a queue that several hardware threads share. It does not hold the entries. It keeps three things: how many entries each thread currently occupies, the most each thread may hold, and how many entries remain free in the whole queue. From these it grants or refuses each thread's allocate request in the same cycle. It also reports, for each thread and for the whole queue, whether space is left.

Per-thread limits come from the set of active threads and a selectable sharing mode:
- **Dynamic:** every thread may use the whole queue.
- **Split:** active threads divide the queue evenly.
- **Capped:** each thread is held to a programmable ceiling.

Limits are registered, so a change to the active mask, the mode or the ceiling takes effect at the next clock edge.

Entries are returned in two ways. A thread can release one entry per cycle. A squash removes a whole batch of entries from one thread at once.

Top module: `smt_entry_budget`

## Requirements
- R1: After reset every thread count is 0 and `free_total` is TOTAL (32). All limits are 0, so `thr_full` is all ones until the first clock edge with reset released.
- R2: Dynamic mode (mode code 0, and also the reserved code 3) gives every active thread a limit of TOTAL. Each limit is sampled at a clock edge and holds from the following cycle. Inactive threads get a limit of 0 in every mode.
- R3: Split mode (code 1) gives each active thread a limit of TOTAL divided by the number of active threads, rounded down.
- R4: Capped mode (code 2) gives each active thread a limit equal to the ceiling input, clamped to at most TOTAL.
- R5: `alloc_gnt[t]` is high in the same cycle only when all four hold: `alloc_req[t]` is high, thread t is active, its count is below its limit, and a global entry remains. Global entries go to the lowest thread index first. A grant adds one to the count at the next edge.
- R6: `free_total` always equals TOTAL minus the sum of all thread counts. `all_full` is high exactly when `free_total` is 0.
- R7: `thr_full[t]` is high exactly when thread t's count is at or above its limit.
- R8: `thr_free[t]` is the smaller of two values: the thread's remaining headroom (its limit minus its count, floored at 0) and `free_total`.
- R9: A granted allocate and a release for the same thread in the same cycle leave that thread's count unchanged.
- R10: A release or squash never takes a count below 0. A release on a thread holding no entries has no effect.
- R11: A squash subtracts `squash_cnt` from thread `squash_tid` in one cycle. It adds to any single release for that thread in the same cycle.
- R12: An allocate request from a thread whose `active_mask` bit is 0 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | THREADS | Per-thread allocate request, one entry each |
| rel_req | input | THREADS | Per-thread release of one entry |
| squash_vld | input | 1 | Bulk release valid |
| squash_tid | input | TID_W | Thread hit by the bulk release |
| squash_cnt | input | CNT_W | Number of entries the bulk release removes |
| active_mask | input | THREADS | Threads currently running |
| share_mode | input | 2 | 0 dynamic, 1 split, 2 capped, 3 dynamic |
| cap_limit | input | CNT_W | Ceiling for capped mode |
| alloc_gnt | output | THREADS | Allocate accepted this cycle |
| thr_full | output | THREADS | Thread at or above its limit |
| all_full | output | 1 | No free entry in the queue |
| free_total | output | CNT_W | Free entries in the queue |
| thr_free | output | THREADS x CNT_W | Entries each thread could still obtain |
| thr_count | output | THREADS x CNT_W | Entries each thread holds |

## Verification
Directed sequences first drive one thread until the whole queue is exhausted. This separates the global refusal from the per-thread refusal, and a second thread's refused request shows that the global budget is shared.

Split mode with three active threads checks that the limit is rounded down (10 entries each) and that the inactive thread gets 0. Capped mode is run with a ceiling above TOTAL and one below it, which checks the clamp.

Combined allocate and release, oversize squashes and releases on empty threads probe the update arithmetic at its edges.

A long seeded random phase mixes requests from all threads with mode and mask changes, and compares every output each cycle against a bench model. Simultaneous requests near exhaustion in this phase expose any error in the lowest-index-first priority.

// File: rtl/smt_budget_pkg.sv
package smt_budget_pkg;
    typedef enum logic [1:0] {
        SHARE_DYNAMIC = 2'd0,
        SHARE_SPLIT   = 2'd1,
        SHARE_CAP     = 2'd2,
        SHARE_RSVD    = 2'd3
    } share_mode_e;
endpackage

// File: rtl/smt_budget_limits.sv
module smt_budget_limits
    import smt_budget_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int TOTAL   = 32,
    parameter int CNT_W   = $clog2(TOTAL + 1)
) (
    input  logic [THREADS-1:0]            active,
    input  logic [1:0]                    mode,
    input  logic [CNT_W-1:0]              cap,
    output logic [THREADS-1:0][CNT_W-1:0] limit
);
    int unsigned          n_act;
    logic [CNT_W-1:0]     share;
    logic [CNT_W-1:0]     cap_c;
    logic [CNT_W-1:0]     mode_lim;

    always_comb begin
        n_act = 0;
        for (int i = 0; i < THREADS; i++) begin
            n_act = n_act + {31'd0, active[i]};
        end
        share = (n_act == 0) ? '0 : CNT_W'(TOTAL / n_act);
        cap_c = (int'(cap) > TOTAL) ? CNT_W'(TOTAL) : cap;
        case (share_mode_e'(mode))
            SHARE_SPLIT: mode_lim = share;
            SHARE_CAP:   mode_lim = cap_c;
            default:     mode_lim = CNT_W'(TOTAL);
        endcase
        for (int t = 0; t < THREADS; t++) begin
            limit[t] = active[t] ? mode_lim : '0;
        end
    end
endmodule

// File: rtl/smt_budget_grant.sv
module smt_budget_grant #(
    parameter int THREADS = 4,
    parameter int CNT_W   = 6
) (
    input  logic [THREADS-1:0]            req,
    input  logic [THREADS-1:0]            active,
    input  logic [THREADS-1:0][CNT_W-1:0] count,
    input  logic [THREADS-1:0][CNT_W-1:0] limit,
    input  logic [CNT_W-1:0]              free,
    output logic [THREADS-1:0]            gnt
);
    logic [CNT_W:0] used;

    always_comb begin
        used = '0;
        for (int t = 0; t < THREADS; t++) begin
            gnt[t] = req[t] && active[t] && (count[t] < limit[t])
                     && ({1'b0, free} > used);
            if (gnt[t]) begin
                used = used + (CNT_W + 1)'(1);
            end
        end
    end
endmodule

// File: rtl/smt_entry_budget.sv
module smt_entry_budget #(
    parameter int THREADS = 4,
    parameter int TOTAL   = 32,
    parameter int CNT_W   = $clog2(TOTAL + 1),
    parameter int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [THREADS-1:0]            alloc_req,
    input  logic [THREADS-1:0]            rel_req,
    input  logic                          squash_vld,
    input  logic [TID_W-1:0]              squash_tid,
    input  logic [CNT_W-1:0]              squash_cnt,
    input  logic [THREADS-1:0]            active_mask,
    input  logic [1:0]                    share_mode,
    input  logic [CNT_W-1:0]              cap_limit,
    output logic [THREADS-1:0]            alloc_gnt,
    output logic [THREADS-1:0]            thr_full,
    output logic                          all_full,
    output logic [CNT_W-1:0]              free_total,
    output logic [THREADS-1:0][CNT_W-1:0] thr_free,
    output logic [THREADS-1:0][CNT_W-1:0] thr_count
);
    localparam int SUM_W = CNT_W + 2;

    typedef struct packed {
        logic [THREADS-1:0][CNT_W-1:0] cnt;
        logic [THREADS-1:0][CNT_W-1:0] lim;
        logic [CNT_W-1:0]              free;
    } budget_t;

    budget_t                       state_q, state_d;
    logic [THREADS-1:0][CNT_W-1:0] lim_new;
    logic [THREADS-1:0]            gnt;
    logic [CNT_W:0]                up, dec, nxt;
    logic [SUM_W-1:0]              sum;

    smt_budget_limits #(.THREADS(THREADS), .TOTAL(TOTAL), .CNT_W(CNT_W)) u_limits (
        .active (active_mask),
        .mode   (share_mode),
        .cap    (cap_limit),
        .limit  (lim_new)
    );

    smt_budget_grant #(.THREADS(THREADS), .CNT_W(CNT_W)) u_grant (
        .req    (alloc_req),
        .active (active_mask),
        .count  (state_q.cnt),
        .limit  (state_q.lim),
        .free   (state_q.free),
        .gnt    (gnt)
    );

    always_comb begin
        state_d = state_q;
        sum     = '0;
        up      = '0;
        dec     = '0;
        nxt     = '0;
        for (int t = 0; t < THREADS; t++) begin
            up  = {1'b0, state_q.cnt[t]} + (CNT_W + 1)'(gnt[t]);
            dec = (CNT_W + 1)'(rel_req[t]);
            if (squash_vld && (squash_tid == TID_W'(t))) begin
                dec = dec + {1'b0, squash_cnt};
            end
            nxt = (up > dec) ? (up - dec) : '0;
            state_d.cnt[t] = nxt[CNT_W-1:0];
            sum = sum + SUM_W'(nxt[CNT_W-1:0]);
        end
        state_d.free = CNT_W'(SUM_W'(TOTAL) - sum);
        state_d.lim  = lim_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.cnt  <= '0;
            state_q.lim  <= '0;
            state_q.free <= CNT_W'(TOTAL);
        end else begin
            state_q <= state_d;
        end
    end

    logic [CNT_W-1:0] head;

    always_comb begin
        head = '0;
        for (int t = 0; t < THREADS; t++) begin
            thr_full[t] = state_q.cnt[t] >= state_q.lim[t];
            head = (state_q.lim[t] > state_q.cnt[t]) ? (state_q.lim[t] - state_q.cnt[t]) : '0;
            thr_free[t] = (head < state_q.free) ? head : state_q.free;
        end
    end

    assign alloc_gnt  = gnt;
    assign thr_count  = state_q.cnt;
    assign free_total = state_q.free;
    assign all_full   = (state_q.free == '0);
endmodule

// File: rtl/smt_entry_budget_chk.sv
module smt_entry_budget_chk #(
    parameter int THREADS = 4,
    parameter int TOTAL   = 32,
    parameter int CNT_W   = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [THREADS-1:0]            alloc_req,
    input logic [THREADS-1:0]            rel_req,
    input logic                          squash_vld,
    input logic [THREADS-1:0]            active_mask,
    input logic [THREADS-1:0]            alloc_gnt,
    input logic [THREADS-1:0]            thr_full,
    input logic [CNT_W-1:0]              free_total,
    input logic [THREADS-1:0][CNT_W-1:0] thr_count
);
    int occ;
    always_comb begin
        occ = 0;
        for (int t = 0; t < THREADS; t++) occ = occ + int'(thr_count[t]);
    end

    // R6: free count and occupancy always account for every entry
    assert_conserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free_total) + occ) == TOTAL);

    // R5: never more grants in one cycle than free entries
    assert_gnt_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alloc_gnt) <= int'(free_total));

    for (genvar g = 0; g < THREADS; g++) begin : g_thr
        // R7: a full thread is never granted
        assert_gnt_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_gnt[g] |-> !thr_full[g]);
        // R12: inactive threads are never granted
        assert_gnt_active_R12: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_gnt[g] |-> (active_mask[g] && alloc_req[g]));
        // R9: grant plus release holds the count
        assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_gnt[g] && rel_req[g] && !squash_vld) |=> $stable(thr_count[g]));
        // R5: a lone grant adds exactly one entry
        assert_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_gnt[g] && !rel_req[g] && !squash_vld)
            |=> (thr_count[g] == $past(thr_count[g]) + CNT_W'(1)));
    end
endmodule

bind smt_entry_budget smt_entry_budget_chk #(
    .THREADS(THREADS), .TOTAL(TOTAL), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_req   (alloc_req),
    .rel_req     (rel_req),
    .squash_vld  (squash_vld),
    .active_mask (active_mask),
    .alloc_gnt   (alloc_gnt),
    .thr_full    (thr_full),
    .free_total  (free_total),
    .thr_count   (thr_count)
);

// File: tb/smt_entry_budget_tb.sv
`timescale 1ns/1ps
module smt_entry_budget_tb;
    localparam int T   = 4;
    localparam int TOT = 32;
    localparam int CW  = 6;
    localparam int TW  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [T-1:0]      alloc_req = '0, rel_req = '0, active_mask = '0;
    logic              squash_vld = 1'b0;
    logic [TW-1:0]     squash_tid = '0;
    logic [CW-1:0]     squash_cnt = '0, cap_limit = '0;
    logic [1:0]        share_mode = '0;
    logic [T-1:0]      alloc_gnt, thr_full;
    logic              all_full;
    logic [CW-1:0]     free_total;
    logic [T-1:0][CW-1:0] thr_free, thr_count;

    always #2.5 clk = ~clk;

    smt_entry_budget u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .rel_req(rel_req),
        .squash_vld(squash_vld), .squash_tid(squash_tid), .squash_cnt(squash_cnt),
        .active_mask(active_mask), .share_mode(share_mode), .cap_limit(cap_limit),
        .alloc_gnt(alloc_gnt), .thr_full(thr_full), .all_full(all_full),
        .free_total(free_total), .thr_free(thr_free), .thr_count(thr_count)
    );

    int n_chk = 0, n_fail = 0, cycles = 0;
    int m_cnt[T];
    int m_lim[T];

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_lim(int t);
        int n = 0;
        for (int i = 0; i < T; i++) n += int'(active_mask[i]);
        if (!active_mask[t]) return 0;
        case (share_mode)
            2'd1:    return (n == 0) ? 0 : TOT / n;
            2'd2:    return (int'(cap_limit) > TOT) ? TOT : int'(cap_limit);
            default: return TOT;
        endcase
    endfunction

    function automatic int m_free();
        int s = 0;
        for (int t = 0; t < T; t++) s += m_cnt[t];
        return TOT - s;
    endfunction

    function automatic logic [T-1:0] exp_gnt();
        logic [T-1:0] g = '0;
        int used = 0;
        for (int t = 0; t < T; t++) begin
            if (alloc_req[t] && active_mask[t] && m_cnt[t] < m_lim[t] && used < m_free()) begin
                g[t] = 1'b1;
                used++;
            end
        end
        return g;
    endfunction

    task automatic check_all();
        logic [T-1:0] g = exp_gnt();
        int fr = m_free();
        for (int t = 0; t < T; t++) begin
            int head = (m_lim[t] > m_cnt[t]) ? m_lim[t] - m_cnt[t] : 0;
            chk("R5 grant", int'(alloc_gnt[t]), int'(g[t]));
            chk("R10 count", int'(thr_count[t]), m_cnt[t]);
            chk("R7 full", int'(thr_full[t]), int'(m_cnt[t] >= m_lim[t]));
            chk("R8 thr_free", int'(thr_free[t]), (head < fr) ? head : fr);
        end
        chk("R6 free", int'(free_total), fr);
        chk("R6 all_full", int'(all_full), int'(fr == 0));
    endtask

    task automatic update_model();
        logic [T-1:0] g = exp_gnt();
        for (int t = 0; t < T; t++) begin
            int up = m_cnt[t] + int'(g[t]);
            int dn = int'(rel_req[t]);
            if (squash_vld && int'(squash_tid) == t) dn += int'(squash_cnt);
            m_cnt[t] = (up > dn) ? up - dn : 0;
            m_lim[t] = exp_lim(t);
        end
    endtask

    task automatic cyc();
        #1;
        check_all();
        update_model();
        @(negedge clk);
    endtask

    task automatic idle();
        alloc_req = '0; rel_req = '0; squash_vld = 1'b0;
    endtask

    initial begin
        for (int t = 0; t < T; t++) begin m_cnt[t] = 0; m_lim[t] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 free", int'(free_total), TOT);
        chk("R1 count", int'(thr_count), 0);
        chk("R1 full", int'(thr_full), 4'hF);
        update_model();
        @(negedge clk);

        // R2 dynamic: every active thread may take the whole queue
        share_mode = 2'd0; active_mask = 4'hF; idle(); cyc();
        chk("R2 dynamic", int'(thr_free[2]), TOT);

        // R12 inactive threads refused
        active_mask = 4'b0011; cyc();
        alloc_req = 4'b1100; #1;
        chk("R12 inactive", int'(alloc_gnt), 0);
        cyc(); idle();

        // Fill the queue from thread 0
        active_mask = 4'hF; cyc();
        alloc_req = 4'b0001;
        repeat (36) cyc();
        chk("R6 exhausted", int'(all_full), 1);
        chk("R5 fill", int'(thr_count[0]), TOT);
        alloc_req = 4'b0010; #1;
        chk("R5 global refuse", int'(alloc_gnt[1]), 0);
        cyc();

        // R9 alloc plus release holds count
        idle(); rel_req = 4'b0001; cyc();
        alloc_req = 4'b0001; rel_req = 4'b0001; cyc();
        chk("R9 hold", int'(thr_count[0]), 31);
        idle();

        // R11 squash plus release
        squash_vld = 1'b1; squash_tid = 2'd0; squash_cnt = 6'd20; rel_req = 4'b0001; cyc();
        chk("R11 squash", int'(thr_count[0]), 10);
        rel_req = '0; squash_cnt = 6'd63; cyc();
        chk("R10 squash floor", int'(thr_count[0]), 0);
        idle(); rel_req = 4'b1000; cyc();
        chk("R10 empty release", int'(thr_count[3]), 0);
        idle();

        // R3 split among three threads
        share_mode = 2'd1; active_mask = 4'b0111; cyc();
        chk("R3 share", int'(thr_free[0]), 10);
        chk("R3 inactive", int'(thr_free[3]), 0);
        alloc_req = 4'b0010; repeat (15) cyc();
        chk("R3 cap count", int'(thr_count[1]), 10);
        chk("R3 full", int'(thr_full[1]), 1);
        idle(); squash_vld = 1'b1; squash_tid = 2'd1; squash_cnt = 6'd63; cyc(); idle();

        // R4 capped mode
        share_mode = 2'd2; active_mask = 4'hF; cap_limit = 6'd40; cyc();
        chk("R4 clamp", int'(thr_free[2]), TOT);
        cap_limit = 6'd5; cyc();
        chk("R4 cap", int'(thr_free[2]), 5);
        alloc_req = 4'b0100; repeat (7) cyc();
        chk("R4 cap count", int'(thr_count[2]), 5);
        chk("R4 full", int'(thr_full[2]), 1);
        idle();

        // Random phase
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            alloc_req  = T'($urandom);
            rel_req    = (($urandom % 3) == 0) ? T'($urandom) : '0;
            squash_vld = (($urandom % 16) == 0);
            squash_tid = TW'($urandom);
            squash_cnt = CW'($urandom % 12);
            if (($urandom % 48) == 0) active_mask = T'($urandom);
            if (($urandom % 48) == 0) share_mode = 2'($urandom);
            if (($urandom % 48) == 0) cap_limit = CW'($urandom % 41);
            cyc();
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule